// File: doc/BRIEF.md
# DRAM Current-Test Command Loop Generator

This block produces the endlessly repeating command stream that a DRAM operating-current measurement needs. Mode 0 cycles an activate and a precharge on a single bank. Mode 1 adds a read between them. Every cycle that carries no command is a deselect cycle. On those cycles the command and address lines flip between all-zero and all-one, so the input receivers keep switching while the measurement runs.

The mode and four cycle counts are sampled when `start` rises from idle: the row cycle, the row-active time, the activate-to-read delay and the CAS latency. The loop then runs until `start` is low at a loop boundary. A `loop_done` strobe marks the last cycle of every loop. The block always targets bank 0 and never drives address bit 10 high. It also presents the burst-length field, fixed at eight beats, that the mode register is expected to hold.

Top module: `dram_idd_loop_gen`

## Requirements
- R1: While reset (`rst_n` low, synchronous) has been applied, and while idle, `cs_n`, `ras_n`, `cas_n` and `we_n` are all 1, `addr` and `ba` are 0 and `loop_done` is 0.
- R2: `start` high in idle makes the cycle after the sampling edge loop cycle 0, which carries an activate (`{cs_n,ras_n,cas_n,we_n}` = 4'b0011).
- R3: Loop cycle `t_ras` carries a precharge (4'b0010) with `addr` 0.
- R4: In mode 1, loop cycle `t_rcd` carries a read (4'b0101) with `addr` 0. In mode 0 no read is issued.
- R5: A loop lasts `t_rc` cycles in mode 0. In mode 1 it lasts the larger of `t_rc` and `t_rcd + t_cl + 4`, so that the 8-beat read burst is finished before the next activate.
- R6: Every other loop cycle has `cs_n` = 1. On odd loop cycles `ras_n`, `cas_n`, `we_n` and every `addr` bit except bit 10 are 1. On even loop cycles they are all 0.
- R7: `addr[10]` is always 0 and `ba` is always 0.
- R8: `loop_done` is 1 for exactly the last cycle of each loop.
- R9: If `start` is high on a loop's last cycle, the next loop begins at once. If it is low, the block returns to idle. Dropping `start` mid-loop does not shorten that loop.
- R10: Mode and timing inputs are sampled only when a run starts. Changing them during a run has no effect.
- R11: The activate row address equals the loop index since the run started (first loop 0), with bit 10 cleared.
- R12: `bl_code` is always 2'b00, the fixed 8-beat burst field.
- R13: Legal settings are 2 <= `t_rcd`, `t_rcd` + 2 <= `t_ras`, `t_ras` + 2 <= `t_rc`. Under these settings a deselect cycle follows every command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Run request, sampled in idle and at loop ends |
| mode | input | 1 | 0: activate/precharge loop, 1: activate/read/precharge loop |
| t_rc | input | CW | Row cycle in clocks |
| t_ras | input | CW | Row-active time in clocks |
| t_rcd | input | CW | Activate-to-read delay in clocks |
| t_cl | input | CW | CAS latency in clocks |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe |
| cas_n | output | 1 | Column strobe |
| we_n | output | 1 | Write enable |
| addr | output | AW | Row/column address |
| ba | output | BW | Bank address (always 0) |
| loop_done | output | 1 | Last cycle of a loop |
| bl_code | output | 2 | Expected burst-length field (2'b00) |

## Verification
The loop is exercised with six timing sets. The nominal 800 MT/s set in both modes distinguishes a read-less loop from one with a read. A mode-1 set whose read burst overruns the row cycle proves the loop is stretched. A set where the burst ends exactly at `t_rc` separates a correct `max` from an off-by-one. A tight set with the precharge two cycles before the loop end catches a wrongly placed precharge. A set with an odd `t_rcd` exposes a read that lands on the wrong filler parity. Every run changes the inputs mid-loop and drops `start` mid-loop, and a separate run is reset mid-loop.

// File: rtl/dram_idd_loop_gen.sv
module dram_idd_loop_gen #(
  parameter int AW = 14,
  parameter int BW = 3,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          mode,
  input  logic [CW-1:0] t_rc,
  input  logic [CW-1:0] t_ras,
  input  logic [CW-1:0] t_rcd,
  input  logic [CW-1:0] t_cl,
  output logic          cs_n,
  output logic          ras_n,
  output logic          cas_n,
  output logic          we_n,
  output logic [AW-1:0] addr,
  output logic [BW-1:0] ba,
  output logic          loop_done,
  output logic [1:0]    bl_code
);
  localparam int LW = CW + 2;
  localparam logic [AW-1:0] ADDR_ONES = ~(AW'(1) << 10);
  localparam logic [LW-1:0] BURST_CLK = LW'(4);

  logic          run;
  logic          mode_q;
  logic [LW-1:0] len_q, ras_q, rcd_q, cnt;
  logic [AW-1:0] row_q;
  logic [LW-1:0] rd_end, len_d;
  logic          last, is_act, is_rd, is_pre;

  assign rd_end = {2'b00, t_rcd} + {2'b00, t_cl} + BURST_CLK;
  assign len_d  = (mode && rd_end > {2'b00, t_rc}) ? rd_end : {2'b00, t_rc};
  assign last   = run && (cnt == len_q - LW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0; mode_q <= 1'b0; cnt <= '0; row_q <= '0;
      len_q <= '0; ras_q <= '0; rcd_q <= '0;
    end else if (!run) begin
      if (start) begin
        run    <= 1'b1;
        cnt    <= '0;
        row_q  <= '0;
        mode_q <= mode;
        len_q  <= len_d;
        ras_q  <= {2'b00, t_ras};
        rcd_q  <= {2'b00, t_rcd};
      end
    end else if (last) begin
      cnt   <= '0;
      row_q <= row_q + AW'(1);
      run   <= start;
    end else begin
      cnt <= cnt + LW'(1);
    end
  end

  assign is_act = run && cnt == '0;
  assign is_rd  = run && mode_q && cnt == rcd_q;
  assign is_pre = run && cnt == ras_q;

  always_comb begin
    {cs_n, ras_n, cas_n, we_n} = 4'b1111;
    addr = '0;
    if (is_act) begin
      {cs_n, ras_n, cas_n, we_n} = 4'b0011;
      addr = row_q & ADDR_ONES;
    end else if (is_rd) begin
      {cs_n, ras_n, cas_n, we_n} = 4'b0101;
    end else if (is_pre) begin
      {cs_n, ras_n, cas_n, we_n} = 4'b0010;
    end else if (run) begin
      {ras_n, cas_n, we_n} = {3{cnt[0]}};
      addr = cnt[0] ? ADDR_ONES : '0;
    end
  end

  assign ba        = '0;
  assign loop_done = last;
  assign bl_code   = 2'b00;

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> (cs_n && ras_n && cas_n && we_n && !loop_done && addr == '0));
  assert_restart_act_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_done && start) |=> (!cs_n && !ras_n && cas_n && we_n));
  assert_stop_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_done && !start) |=> (cs_n && ras_n && cas_n && we_n && addr == '0));
  assert_gap_after_cmd_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |=> cs_n);
  assert_bank_a10_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> (ba == '0 && !addr[10]));
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    loop_done |=> !loop_done);
  assert_pre_in_loop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !ras_n && !we_n) |-> (!loop_done && addr == '0));
endmodule

// File: tb/tb_dram_idd_loop_gen.sv
module tb_dram_idd_loop_gen;
  localparam int AW = 14, BW = 3, CW = 8;
  localparam logic [AW-1:0] ONES = ~(AW'(1) << 10);
  localparam int NV = 6;
  // {mode, t_rc, t_ras, t_rcd, t_cl, loops}
  localparam logic [47:0] VEC [NV] = '{
    {8'd0, 8'd20, 8'd15, 8'd5, 8'd5, 8'd3},
    {8'd1, 8'd20, 8'd15, 8'd5, 8'd5, 8'd3},
    {8'd1, 8'd12, 8'd8,  8'd5, 8'd6, 8'd2},
    {8'd0, 8'd7,  8'd5,  8'd2, 8'd2, 8'd4},
    {8'd1, 8'd9,  8'd6,  8'd2, 8'd3, 8'd2},
    {8'd1, 8'd10, 8'd6,  8'd3, 8'd7, 8'd2}
  };

  logic clk = 0, rst_n = 0, start = 0, mode = 0;
  logic [CW-1:0] t_rc = 0, t_ras = 0, t_rcd = 0, t_cl = 0;
  logic cs_n, ras_n, cas_n, we_n, loop_done;
  logic [AW-1:0] addr;
  logic [BW-1:0] ba;
  logic [1:0] bl_code;
  int checks = 0, fails = 0, cyc = 0;

  always #2 clk = ~clk;

  dram_idd_loop_gen #(.AW(AW), .BW(BW), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .t_rc(t_rc), .t_ras(t_ras), .t_rcd(t_rcd), .t_cl(t_cl),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .ba(ba), .loop_done(loop_done), .bl_code(bl_code));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [3:0] ecmd,
                     input logic [AW-1:0] eaddr, input logic edone);
    checks++;
    if ({cs_n, ras_n, cas_n, we_n} !== ecmd || addr !== eaddr ||
        ba !== '0 || loop_done !== edone) begin
      fails++;
      $display("FAIL %s: actual cmd=%b addr=%h ba=%0d done=%b expected cmd=%b addr=%h ba=0 done=%b",
               tag, {cs_n, ras_n, cas_n, we_n}, addr, ba, loop_done, ecmd, eaddr, edone);
    end
  endtask

  task automatic run_vec(input logic [47:0] v);
    int m = int'(v[47:40]), rc = int'(v[39:32]), ras = int'(v[31:24]);
    int rcd = int'(v[23:16]), cl = int'(v[15:8]), nl = int'(v[7:0]);
    int len = (m == 1 && rcd + cl + 4 > rc) ? rcd + cl + 4 : rc; // R5
    @(negedge clk);
    mode = m[0]; t_rc = CW'(rc); t_ras = CW'(ras); t_rcd = CW'(rcd); t_cl = CW'(cl);
    start = 1;
    for (int l = 0; l < nl; l++) begin
      for (int c = 0; c < len; c++) begin
        logic ed;
        @(negedge clk);
        ed = (c == len - 1); // R8
        if (c == 0) chk("R2 R11 activate", 4'b0011, AW'(l) & ONES, ed);
        else if (m == 1 && c == rcd) chk("R4 read", 4'b0101, '0, ed);
        else if (c == ras) chk("R3 precharge", 4'b0010, '0, ed);
        else chk("R6 R5 filler", c[0] ? 4'b1111 : 4'b1000, c[0] ? ONES : '0, ed);
        if (l == 0 && c == 1) begin // R10: inputs change mid-run
          mode = ~mode; t_rc = 3; t_ras = 1; t_rcd = 1; t_cl = 0;
        end
        if (l == nl - 1 && c == 1) start = 0; // R9: mid-loop drop
      end
    end
    @(negedge clk);
    chk("R9 R1 idle after stop", 4'b1111, '0, 1'b0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 reset", 4'b1111, '0, 1'b0);
    checks++;
    if (bl_code !== 2'b00) begin
      fails++;
      $display("FAIL R12: actual=%b expected=00", bl_code);
    end
    rst_n = 1;
    @(negedge clk);
    chk("R1 idle", 4'b1111, '0, 1'b0);
    for (int i = 0; i < NV; i++) run_vec(VEC[i]);
    // R1: reset in mid-loop
    @(negedge clk);
    mode = 0; t_rc = 20; t_ras = 15; t_rcd = 5; t_cl = 5; start = 1;
    repeat (4) @(negedge clk);
    chk("R6 before reset", 4'b1111, ONES, 1'b0);
    rst_n = 0; start = 0;
    @(negedge clk);
    chk("R1 mid-loop reset", 4'b1111, '0, 1'b0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 stays idle", 4'b1111, '0, 1'b0);
    checks++;
    if (bl_code !== 2'b00) begin
      fails++;
      $display("FAIL R12: actual=%b expected=00", bl_code);
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule